// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the operand fields of a decoded instruction into the one result the rest of a small 8-bit controller core needs: an effective memory address, an immediate data value, or a jump target. It sits between the instruction decoder and the memory and program-counter logic. The memory map is one 12-bit space that program and data share.

Each cycle the decoder presents an addressing-mode code, an immediate-width select, a 12-bit operand field and the current 12-bit index pointer. One clock later the block presents the resolved value on one of three result buses. Exactly one matching valid flag is raised, or none at all for modes that have no operand. Direct and indirect accesses are limited to the low 256 data locations. The indexed sum is the only way to reach an address above 0x0FF. Relative jumps are resolved elsewhere, so this block reports no result for them.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low, every result bus reads zero and all three valid flags are low.
- R2: Mode code 0 (inherent) raises no valid flag on the next cycle.
- R3: Mode code 1 (immediate) with `imm_width_i`=0 gives `data_o` = `operand_i[2:0]` zero-extended to 12 bits, with only `data_vld_o` high.
- R4: Mode code 1 with `imm_width_i`=1 gives `data_o` = `operand_i[7:0]` zero-extended, with only `data_vld_o` high.
- R5: Mode code 1 with `imm_width_i`=2 or 3 gives `data_o` = `operand_i[11:0]`, with only `data_vld_o` high.
- R6: Mode code 2 (direct) gives `addr_o` = {4'h0, `operand_i[7:0]`}, with only `addr_vld_o` high.
- R7: Mode code 3 (indirect) gives `addr_o` = {4'h0, `xptr_i[7:0]`}, with only `addr_vld_o` high. The operand field has no effect on the result.
- R8: Mode code 4 (indexed) gives `addr_o` = (`xptr_i` + `operand_i[7:0]`) mod 4096, with the offset taken as unsigned, and only `addr_vld_o` high.
- R9: Mode code 5 (absolute jump) gives `target_o` = `operand_i[11:0]`, with only `tgt_vld_o` high.
- R10: Mode code 6 (relative jump) and the unused code 7 raise no valid flag.
- R11: Each result appears on the clock edge that follows the inputs it is computed from. At most one valid flag is high in any cycle.
- R12: A result bus whose valid flag is low reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Addressing-mode code (0 inherent … 7 unused) |
| imm_width_i | input | 2 | Immediate width: 0 = 3 bits, 1 = 8 bits, 2/3 = 12 bits |
| operand_i | input | 12 | Operand field taken from the instruction |
| xptr_i | input | 12 | Current index pointer |
| addr_o | output | 12 | Effective memory address |
| data_o | output | 12 | Zero-extended immediate data |
| target_o | output | 12 | New program-counter value |
| addr_vld_o | output | 1 | `addr_o` holds a result |
| data_vld_o | output | 1 | `data_o` holds a result |
| tgt_vld_o | output | 1 | `target_o` holds a result |

## Verification
The assertions assume that `mode_i`, `imm_width_i`, `operand_i` and `xptr_i` hold known values on every sampled edge once reset is released. The bench therefore drives all of them from time zero and changes them only on falling edges. Every mode code, including the relative and unused ones, appears with every width select. Operand and pointer values include all-ones patterns and pointers near 0xFFF, so that the indexed sum wraps. Non-zero upper operand bits are also fed to modes that must ignore them.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int ADDR_W = 12;
    localparam int BYTE_W = 8;
    localparam int SHORT_W = 3;

    typedef enum logic [2:0] {
        M_INH  = 3'd0,
        M_IMM  = 3'd1,
        M_DIR  = 3'd2,
        M_IND  = 3'd3,
        M_IDX  = 3'd4,
        M_ABS  = 3'd5,
        M_REL  = 3'd6,
        M_NONE = 3'd7
    } mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] data;
        logic [ADDR_W-1:0] tgt;
        logic              addr_vld;
        logic              data_vld;
        logic              tgt_vld;
    } eag_res_t;
endpackage

// File: rtl/eag_imm_ext.sv
module eag_imm_ext #(
    parameter int OUT_W   = 12,
    parameter int BYTE_W  = 8,
    parameter int SHORT_W = 3
) (
    input  logic [1:0]       width_i,
    input  logic [OUT_W-1:0] field_i,
    output logic [OUT_W-1:0] value_o
);
    localparam int SHORT_PAD = OUT_W - SHORT_W;
    localparam int BYTE_PAD  = OUT_W - BYTE_W;

    logic [OUT_W-1:0] short_ext;
    logic [OUT_W-1:0] byte_ext;

    generate
        if (SHORT_PAD > 0) begin : g_short_pad
            assign short_ext = {{SHORT_PAD{1'b0}}, field_i[SHORT_W-1:0]};
        end else begin : g_short_full
            assign short_ext = field_i;
        end
        if (BYTE_PAD > 0) begin : g_byte_pad
            assign byte_ext = {{BYTE_PAD{1'b0}}, field_i[BYTE_W-1:0]};
        end else begin : g_byte_full
            assign byte_ext = field_i;
        end
    endgenerate

    always_comb begin
        unique case (width_i)
            2'd0:    value_o = short_ext;
            2'd1:    value_o = byte_ext;
            default: value_o = field_i;
        endcase
    end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] field_i,
    input  logic [ADDR_W-1:0] xptr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              hit_o
);
    import eag_pkg::*;
    localparam int PAD_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] page0_op;
    logic [ADDR_W-1:0] page0_x;
    logic [ADDR_W-1:0] idx_sum;

    assign offset   = {{PAD_W{1'b0}}, field_i[BYTE_W-1:0]};
    assign page0_op = offset;
    assign page0_x  = {{PAD_W{1'b0}}, xptr_i[BYTE_W-1:0]};
    // Sum is truncated to ADDR_W, giving modulo wrap over the whole map.
    assign idx_sum  = xptr_i + offset;

    always_comb begin
        addr_o = '0;
        hit_o  = 1'b0;
        unique case (mode_e'(mode_i))
            M_DIR: begin addr_o = page0_op; hit_o = 1'b1; end
            M_IND: begin addr_o = page0_x;  hit_o = 1'b1; end
            M_IDX: begin addr_o = idx_sum;  hit_o = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
    parameter int ADDR_W  = 12,
    parameter int BYTE_W  = 8,
    parameter int SHORT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        imm_width_i,
    input  logic [ADDR_W-1:0] operand_i,
    input  logic [ADDR_W-1:0] xptr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] data_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              addr_vld_o,
    output logic              data_vld_o,
    output logic              tgt_vld_o
);
    import eag_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] data;
        logic [ADDR_W-1:0] tgt;
        logic              addr_vld;
        logic              data_vld;
        logic              tgt_vld;
    } res_t;

    res_t res_d, res_q;

    logic [ADDR_W-1:0] imm_val;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_hit;

    eag_imm_ext #(
        .OUT_W  (ADDR_W),
        .BYTE_W (BYTE_W),
        .SHORT_W(SHORT_W)
    ) i_imm (
        .width_i(imm_width_i),
        .field_i(operand_i),
        .value_o(imm_val)
    );

    eag_addr_calc #(
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
    ) i_addr (
        .mode_i (mode_i),
        .field_i(operand_i),
        .xptr_i (xptr_i),
        .addr_o (mem_addr),
        .hit_o  (mem_hit)
    );

    always_comb begin
        res_d          = '0;
        res_d.addr     = mem_addr;
        res_d.addr_vld = mem_hit;
        unique case (mode_e'(mode_i))
            M_IMM: begin
                res_d.data     = imm_val;
                res_d.data_vld = 1'b1;
            end
            M_ABS: begin
                res_d.tgt     = operand_i;
                res_d.tgt_vld = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign addr_o     = res_q.addr;
    assign data_o     = res_q.data;
    assign target_o   = res_q.tgt;
    assign addr_vld_o = res_q.addr_vld;
    assign data_vld_o = res_q.data_vld;
    assign tgt_vld_o  = res_q.tgt_vld;

    p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_vld_o, data_vld_o, tgt_vld_o}));

    p_silent_inh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 3'd0 |=> !(addr_vld_o || data_vld_o || tgt_vld_o));

    p_short_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd1 && imm_width_i == 2'd0)
        |=> data_vld_o && data_o[ADDR_W-1:SHORT_W] == '0);

    p_dir_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 3'd2 |=> addr_vld_o && addr_o[ADDR_W-1:BYTE_W] == '0);

    p_ind_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 3'd3 |=> addr_vld_o && addr_o == {{(ADDR_W-BYTE_W){1'b0}}, $past(xptr_i[BYTE_W-1:0])});

    p_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 3'd5 |=> tgt_vld_o && target_o == $past(operand_i));

    p_no_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[2:1] == 2'b11 |=> !(addr_vld_o || data_vld_o || tgt_vld_o));

    p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_vld_o -> addr_o == '0) && (!data_vld_o -> data_o == '0)
        && (!tgt_vld_o -> target_o == '0));
endmodule

// File: tb/test_eag_top.sv
module test_eag_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  imm_width_i = '0;
    logic [11:0] operand_i = '0;
    logic [11:0] xptr_i = '0;
    logic [11:0] addr_o, data_o, target_o;
    logic        addr_vld_o, data_vld_o, tgt_vld_o;

    int total = 0;
    int bad = 0;
    int lfsr = 32'h1d2c3b4a;

    logic [11:0] e_addr, e_data, e_tgt;
    logic        e_av, e_dv, e_tv;
    string       e_req;

    always #(CLK_P/2) clk = ~clk;

    eag_top i_eag_top (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .imm_width_i(imm_width_i),
        .operand_i(operand_i), .xptr_i(xptr_i), .addr_o(addr_o), .data_o(data_o),
        .target_o(target_o), .addr_vld_o(addr_vld_o), .data_vld_o(data_vld_o),
        .tgt_vld_o(tgt_vld_o)
    );

    // Reference model: expectations come straight from the requirement text.
    task automatic model(input int m, input int w, input int op, input int x);
        e_addr = '0; e_data = '0; e_tgt = '0;
        e_av = 0; e_dv = 0; e_tv = 0;
        case (m)
            0: e_req = "R2";
            1: begin
                e_dv = 1;
                if (w == 0)      begin e_data = 12'(op % 8);   e_req = "R3"; end
                else if (w == 1) begin e_data = 12'(op % 256); e_req = "R4"; end
                else             begin e_data = 12'(op % 4096); e_req = "R5"; end
            end
            2: begin e_av = 1; e_addr = 12'(op % 256); e_req = "R6"; end
            3: begin e_av = 1; e_addr = 12'(x % 256);  e_req = "R7"; end
            4: begin e_av = 1; e_addr = 12'((x % 4096 + op % 256) % 4096); e_req = "R8"; end
            5: begin e_tv = 1; e_tgt = 12'(op % 4096); e_req = "R9"; end
            default: e_req = "R10";
        endcase
    endtask

    task automatic compare(input string req);
        total++;
        if (addr_o !== e_addr || data_o !== e_data || target_o !== e_tgt ||
            addr_vld_o !== e_av || data_vld_o !== e_dv || tgt_vld_o !== e_tv) begin
            bad++;
            $display("FAIL %s (R11/R12 timing and quiet buses): got a=%h d=%h t=%h v=%b%b%b exp a=%h d=%h t=%h v=%b%b%b",
                req, addr_o, data_o, target_o, addr_vld_o, data_vld_o, tgt_vld_o,
                e_addr, e_data, e_tgt, e_av, e_dv, e_tv);
        end
    endtask

    // Drive at a falling edge; the result shows after the next rising edge,
    // and is checked at the following falling edge.
    task automatic step(input int m, input int w, input int op, input int x);
        mode_i = 3'(m); imm_width_i = 2'(w); operand_i = 12'(op); xptr_i = 12'(x);
        model(m, w, op, x);
        @(negedge clk);
        compare(e_req);
    endtask

    function automatic int next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >>> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr & 32'h7fffffff;
    endfunction

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got running, exp finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mode_i = 3'd5; operand_i = 12'hABC; xptr_i = 12'hFFF; imm_width_i = 2'd2;
        repeat (3) @(negedge clk);
        // R1: reset holds every output at zero despite active inputs
        e_addr = '0; e_data = '0; e_tgt = '0; e_av = 0; e_dv = 0; e_tv = 0;
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);

        step(0, 0, 12'hFFF, 12'hFFF);          // R2
        step(1, 0, 12'hFFF, 12'h000);          // R3 upper bits dropped
        step(1, 0, 12'h005, 12'h000);          // R3
        step(1, 1, 12'hF5A, 12'h000);          // R4
        step(1, 2, 12'hF5A, 12'h000);          // R5
        step(1, 3, 12'h801, 12'h000);          // R5 width code 3
        step(2, 0, 12'hEFF, 12'h123);          // R6 upper operand ignored
        step(3, 0, 12'hFFF, 12'hA42);          // R7 operand ignored
        step(3, 0, 12'h000, 12'hA42);          // R7 same result
        step(4, 0, 12'h0FF, 12'hFFF);          // R8 wrap
        step(4, 0, 12'hF10, 12'h7F8);          // R8 program-space reach
        step(5, 0, 12'hFFF, 12'h000);          // R9
        step(6, 1, 12'h01F, 12'h100);          // R10 relative
        step(7, 2, 12'hFFF, 12'hFFF);          // R10 unused code
        step(5, 0, 12'h000, 12'h000);          // R9 zero target
        for (int i = 0; i < 400; i++) begin
            step(next_rand() % 8, next_rand() % 4, next_rand() % 4096, next_rand() % 4096);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule